// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Per-Pin Interrupt Detection

This block is an eight-pin general purpose I/O port placed on a simple APB-style register bus with zero wait states. Software chooses, pin by pin, whether the pin drives or samples. It reads and writes pin data through an address window in which the word address acts as a bit mask. This lets a single pin be set or cleared with one store, with no read-modify-write.

Every pin owns an interrupt detector. The detector can be set to respond to a high or low level, to a rising or falling edge, or to both edges. Edge events are held until software clears them by writing ones. Level events track the pin and are not held. The raw detector outputs are visible to software, and so are their values after the per-pin enable. The enabled bits are ORed into one registered interrupt line.

External inputs pass through a two-flop synchronizer before they are used. Register reads are captured in the bus setup cycle and returned during the access cycle. Register writes take effect at the access cycle.

Top module: `gpio_mmio`

## Requirements
- R1: After reset, the direction, data, sense, both-edge, event and enable registers are zero. As a result pin_oe, pin_out and irq are 0 and a read of offset 0x400 returns 0.
- R2: A write in the data window (offsets 0x000 to 0x3FC, address bits [11:10] zero) updates pin bit n only when address bit n+2 is 1 and direction bit n is 1. All other stored data bits keep their value.
- R3: A data-window read returns, for each bit whose address bit n+2 is 1, the stored data bit when the pin is an output or the synchronized input when it is an input. Bits whose address bit is 0 read as 0.
- R4: The direction register sits at 0x400, and a 1 makes the pin an output. pin_oe equals the direction register, and pin_out carries the stored data bit only on output pins (0 elsewhere).
- R5: With sense bit 1 (register 0x404), the pin is level-sensed. Its raw status bit (0x414) is 1 while the synchronized input is high (event bit 1) or low (event bit 0). It is not latched, and a clear write does not affect it.
- R6: With sense bit 0 and both-edge bit 0 (register 0x408), a rising edge (event bit 1, register 0x40C) or a falling edge (event bit 0) sets a latched raw status bit. The opposite edge does not set it.
- R7: With sense bit 0 and both-edge bit 1, either edge sets the latched status and the event bit is ignored.
- R8: Writing 1s to offset 0x41C clears the matching latched edge bits, and 0 bits have no effect. An edge detected in the same cycle as the clear leaves the bit set. Reads of 0x41C return 0.
- R9: Offset 0x410 holds the enable bits. Offset 0x418 reads raw status AND enable. irq is the OR of those bits, registered one clock later, and it stays 0 while all enables are 0.
- R10: Reads of unmapped or non-word-aligned offsets (for example 0x420 or 0x401) return 0. Writes to 0x414 and 0x418 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the access phase |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data, gated by direction |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The assertions assume a well-formed bus. Each transfer is one setup cycle with penable low, followed by exactly one access cycle holding the same address and direction. The bench's read and write tasks always produce that two-cycle pattern and park the bus idle between transfers. The assertions also take pin_in as possibly asynchronous, so the detector checks look only at synchronized values. The bench changes pins only on falling clock edges and waits at least four cycles before judging a status bit, except in the deliberate clear-versus-edge collision, where it times the pin change to land the edge exactly on the clear cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADR_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] ADR_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] ADR_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] ADR_EVENT = 12'h40C;
  localparam logic [ADDR_W-1:0] ADR_EN    = 12'h410;
  localparam logic [ADDR_W-1:0] ADR_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] ADR_MSK   = 12'h418;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 12'h41C;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_EVENT,
    SEL_EN, SEL_RAW, SEL_MSK, SEL_CLR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a, input int pins);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if ((a >> (pins + 2)) == '0) s = SEL_DATA;
      else begin
        case (a)
          ADR_DIR:   s = SEL_DIR;
          ADR_SENSE: s = SEL_SENSE;
          ADR_BOTH:  s = SEL_BOTH;
          ADR_EVENT: s = SEL_EVENT;
          ADR_EN:    s = SEL_EN;
          ADR_RAW:   s = SEL_RAW;
          ADR_MSK:   s = SEL_MSK;
          ADR_CLR:   s = SEL_CLR;
          default:   s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q[k] <= '0;
      else     stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic event_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q;
  logic latch_q;
  logic rise, fall, edge_hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    edge_hit = 1'b0;
    if (!sense_i) begin
      if (both_i)       edge_hit = rise | fall;
      else if (event_i) edge_hit = rise;
      else              edge_hit = fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (edge_hit)   latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
    end
  end

  assign raw_o = sense_i ? (event_i ? lvl_i : ~lvl_i) : latch_q;

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> latch_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !edge_hit) |=> !latch_q);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && latch_q) |=> latch_q);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  input  logic [PINS-1:0]   sync_in,
  input  logic [PINS-1:0]   raw_i,
  output logic [PINS-1:0]   prdata,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   dout_o,
  output logic [PINS-1:0]   sense_o,
  output logic [PINS-1:0]   both_o,
  output logic [PINS-1:0]   event_o,
  output logic [PINS-1:0]   en_o,
  output logic [PINS-1:0]   clr_o
);
  reg_sel_e        sel;
  logic            wr_en, rd_setup;
  logic [PINS-1:0] amask, wmask, rd_val;
  logic [PINS-1:0] dir_q, dout_q, sense_q, both_q, event_q, en_q, prdata_q;

  assign sel      = decode_addr(paddr, PINS);
  assign wr_en    = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign amask    = paddr[PINS+1:2];
  assign wmask    = amask & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      dout_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:  dout_q  <= (dout_q & ~wmask) | (pwdata & wmask);
        SEL_DIR:   dir_q   <= pwdata;
        SEL_SENSE: sense_q <= pwdata;
        SEL_BOTH:  both_q  <= pwdata;
        SEL_EVENT: event_q <= pwdata;
        SEL_EN:    en_q    <= pwdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA:  rd_val = ((dir_q & dout_q) | (~dir_q & sync_in)) & amask;
      SEL_DIR:   rd_val = dir_q;
      SEL_SENSE: rd_val = sense_q;
      SEL_BOTH:  rd_val = both_q;
      SEL_EVENT: rd_val = event_q;
      SEL_EN:    rd_val = en_q;
      SEL_RAW:   rd_val = raw_i;
      SEL_MSK:   rd_val = raw_i & en_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata_q <= '0;
    else if (rd_setup) prdata_q <= rd_val;
  end

  assign clr_o   = (wr_en && sel == SEL_CLR) ? pwdata : '0;
  assign prdata  = prdata_q;
  assign dir_o   = dir_q;
  assign dout_o  = dout_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign en_o    = en_q;

  assert_data_guard_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DATA) |=>
      ((dout_q & ~$past(wmask)) == ($past(dout_q) & ~$past(wmask))));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && (sel == SEL_NONE || sel == SEL_CLR)) |=> (prdata == '0));
  assert_ro_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (sel == SEL_RAW || sel == SEL_MSK)) |=>
      ($stable(dir_q) && $stable(dout_q) && $stable(en_q) && $stable(sense_q)));
endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
  import gpio_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  logic [PINS-1:0] sync_in, raw, dir, dout, sense, both, evt, en, clr;
  logic            irq_q;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_in), .q_o(sync_in)
  );

  gpio_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .sync_in(sync_in), .raw_i(raw),
    .prdata(prdata), .dir_o(dir), .dout_o(dout), .sense_o(sense),
    .both_o(both), .event_o(evt), .en_o(en), .clr_o(clr)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk(clk), .rst(rst), .lvl_i(sync_in[n]), .sense_i(sense[n]),
      .both_i(both[n]), .event_i(evt[n]), .clr_i(clr[n]), .raw_o(raw[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw & en);
  end

  assign irq     = irq_q;
  assign pin_oe  = dir;
  assign pin_out = dout & dir;

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
  assert_no_drive_input_R4: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~pin_oe) == '0));
  assert_level_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (sense[0] && $stable(sense[0]) && $stable(evt[0]) && $stable(sync_in[0]))
      |-> $stable(raw[0]));
endmodule

// File: tb/sim_gpio_mmio.sv
module sim_gpio_mmio;
  logic        clk = 0;
  logic        rst = 1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pin_in, pin_out, pin_oe;
  logic        irq;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  gpio_mmio u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [39:0] VECS [6] = '{
    {12'h3FC, 8'hA5, 12'h3FC, 8'hA5},
    {12'h004, 8'h00, 12'h3FC, 8'hA4},
    {12'h3C0, 8'hFF, 12'h03C, 8'h04},
    {12'h000, 8'hFF, 12'h3FC, 8'hF4},
    {12'h204, 8'h00, 12'h204, 8'h00},
    {12'h028, 8'hFF, 12'h3FC, 8'h7E}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, model;
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(12'h400, v); chk("R1 dir", v, 8'h00);

    // R2/R3 table of masked data accesses, all pins outputs
    wr(12'h400, 8'hFF);
    model = 8'h00;
    for (int i = 0; i < 6; i++) begin
      logic [39:0] e;
      logic [7:0] m;
      e = VECS[i];
      m = e[37:30];
      wr(e[39:28], e[27:20]);
      model = (model & ~m) | (e[27:20] & m);
      chk("R2 pin_out", pin_out, model);
      rd(e[19:8], v); chk("R3 masked read", v, e[7:0]);
    end

    // R4 direction and mixed read
    wr(12'h400, 8'h0F);
    chk("R4 pin_oe", pin_oe, 8'h0F);
    chk("R4 pin_out gated", pin_out, 8'h0E);
    @(negedge clk); pin_in = 8'hA0;
    idle(4);
    rd(12'h3FC, v); chk("R3 mixed read", v, 8'hAE);
    wr(12'h3FC, 8'h00);   // only output pins 0..3 take it -> 0x70
    wr(12'h400, 8'hFF);
    chk("R2 input pins not written", pin_out, 8'h70);
    wr(12'h400, 8'h00);

    // R6 falling edges latched with all-zero config
    @(negedge clk); pin_in = 8'h00;
    idle(4);
    rd(12'h414, v); chk("R6 falling latched", v, 8'hA0);
    wr(12'h41C, 8'h20);
    rd(12'h414, v); chk("R8 partial clear", v, 8'h80);
    rd(12'h41C, v); chk("R8 clear reads zero", v, 8'h00);
    wr(12'h41C, 8'hFF);
    rd(12'h414, v); chk("R8 full clear", v, 8'h00);

    // R5 level sensing on pin 0
    wr(12'h404, 8'h01); wr(12'h40C, 8'h01); wr(12'h410, 8'h01);
    rd(12'h414, v); chk("R5 level high idle", v, 8'h00);
    @(negedge clk); pin_in = 8'h01;
    idle(4);
    rd(12'h418, v); chk("R9 masked status", v, 8'h01);
    chk("R9 irq level", {7'd0, irq}, 8'h01);
    @(negedge clk); pin_in = 8'h00;
    idle(4);
    rd(12'h414, v); chk("R5 not latched", v, 8'h00);
    chk("R9 irq drop", {7'd0, irq}, 8'h00);
    wr(12'h40C, 8'h00);
    rd(12'h414, v); chk("R5 low level", v, 8'h01);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R5 clear ignored", v, 8'h01);
    wr(12'h404, 8'h00); wr(12'h41C, 8'hFF); wr(12'h410, 8'h00);

    // R6 rising only on pin 1
    wr(12'h40C, 8'h02); wr(12'h410, 8'h02);
    @(negedge clk); pin_in = 8'h02;
    idle(4);
    rd(12'h414, v); chk("R6 rising", v, 8'h02);
    chk("R9 irq edge", {7'd0, irq}, 8'h01);
    wr(12'h41C, 8'h02);
    @(negedge clk); pin_in = 8'h00;
    idle(4);
    rd(12'h414, v); chk("R6 opposite edge ignored", v, 8'h00);

    // R7 both edges on pin 2, event bit set but ignored
    wr(12'h408, 8'h04); wr(12'h40C, 8'h04); wr(12'h410, 8'h00);
    @(negedge clk); pin_in = 8'h04;
    idle(4);
    rd(12'h414, v); chk("R7 rise", v, 8'h04);
    wr(12'h41C, 8'h04);
    @(negedge clk); pin_in = 8'h00;
    idle(4);
    rd(12'h414, v); chk("R7 fall", v, 8'h04);
    rd(12'h418, v); chk("R9 disabled masked", v, 8'h00);
    chk("R9 irq disabled", {7'd0, irq}, 8'h00);
    wr(12'h41C, 8'h04);
    rd(12'h414, v); chk("R8 cleared before race", v, 8'h00);

    // R8 edge lands on the clear cycle: set wins
    @(negedge clk); pin_in = 8'h04;
    wr(12'h41C, 8'h04);
    rd(12'h414, v); chk("R8 edge beats clear", v, 8'h04);

    // R10 unmapped and read-only
    rd(12'h420, v); chk("R10 unmapped", v, 8'h00);
    rd(12'h401, v); chk("R10 unaligned", v, 8'h00);
    wr(12'h414, 8'h00); wr(12'h418, 8'h00);
    rd(12'h414, v); chk("R10 raw write ignored", v, 8'h04);
    rd(12'h400, v); chk("R10 dir untouched", v, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule